// File: doc/BRIEF.md
# General-Purpose Event Register Block with Hotplug Interrupt

This block holds a bank of general-purpose event registers behind a small byte-wide register window. The window has two halves of equal length. The lower half holds event status bytes and the upper half holds the matching enable bytes. A single hardware source, a hotplug notification, is wired to one fixed status bit. That bit drives a level-sensitive system control interrupt line (`sci`).

When a hotplug event arrives, the block latches it in the status bit. If the matching enable bit is set, the block raises `sci`. Software services the interrupt in one of two ways. It can clear the status bit by writing 1 to it. It can also switch the event off by writing 0 into the enable bit. Either action drops the line.

Register accesses are single-cycle byte operations. Writes take effect at the clock edge. Read data is returned combinationally in the same cycle as the read request.

Top module: `gpe_sci_block`

## Requirements
- R1: After a synchronous active-low reset, every status byte and every enable byte reads 0x00, and `sci` is low.
- R2: Byte addresses 0 to NUM_BYTES-1 select the status bytes in order. Addresses NUM_BYTES to 2*NUM_BYTES-1 select the enable bytes in the same order. A write to one half never changes the other half.
- R3: A status write clears exactly the bits where the write data is 1. Every other bit of that byte keeps its value.
- R4: An enable write loads the whole addressed enable byte with the write data. The new value is readable from the next cycle.
- R5: A one-cycle pulse on `hp_event` sets bit 3 of status byte 0 (address 0). If bit 3 of enable byte 0 was 1 before that cycle, `sci` goes high in the following cycle.
- R6: A hotplug event that arrives while enable byte 0 bit 3 is 0 sets the status bit but leaves `sci` low. Setting the enable bit afterwards does not raise `sci` by itself.
- R7: While `sci` is high, a status write to address 0 that takes bit 3 from 1 to 0 lowers `sci`. A status write that leaves bit 3 set does not lower `sci`.
- R8: A write to enable byte 0 with data bit 3 equal to 0 lowers `sci`. Enable writes that keep bit 3 at 1, and writes to other enable bytes, leave `sci` unchanged.
- R9: When a hotplug event and a software clear of status bit 3 fall in the same cycle, the event wins. The bit stays 1 and `sci` stays high.
- R10: Reads at addresses at or above 2*NUM_BYTES return 0x00. Writes there change no register and do not affect `sci`.
- R11: When a hotplug event coincides with an enable-byte-0 write whose bit 3 is 0, the status bit is set, the enable byte takes the written value, and `sci` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read request, else 0 |
| hp_event | input | 1 | One-cycle hotplug notification pulse |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
The bench instantiates the block with NUM_BYTES = 3 and ADDR_W = 4. This gives a six-byte window with ten unmapped addresses above it. With three bytes per half, there are status and enable bytes beside the hotplug byte, which exposes writes that reach the wrong half or the wrong byte. The gap between six bytes and the 16-address space lets the bench probe the behaviour outside the window. Directed scenarios drive the two interrupt-lowering triggers both alone and colliding with an event in the same cycle, so the priority decisions are observed at `sci`.

// File: rtl/gpe_pkg.sv
// Shared constants and types for the general-purpose event block.
// Assumes byte-wide register access; the hotplug position is fixed by
// the firmware tables that service the interrupt.
package gpe_pkg;

    localparam int BYTE_W  = 8;
    // Position of the hotplug event in the status and enable halves.
    localparam int HP_BYTE = 0;
    localparam int HP_BIT  = 3;

    typedef logic [BYTE_W-1:0] gpe_byte_t;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_STS  = 2'd1,
        RG_EN   = 2'd2
    } gpe_region_e;

endpackage

// File: rtl/gpe_addr_decode.sv
// Address decoder for the event register window.
// Splits a byte address into the status half, the enable half or
// "outside". It produces one-hot write strobes per byte and a byte index
// for the read path.
// Assumes 2*NUM_BYTES fits in ADDR_W bits of address space.
module gpe_addr_decode
    import gpe_pkg::*;
#(
    parameter int NUM_BYTES = 2,
    parameter int ADDR_W    = 8,
    localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    output gpe_region_e          region,
    output logic [IDX_W-1:0]     byte_idx,
    output logic [NUM_BYTES-1:0] sts_wr,
    output logic [NUM_BYTES-1:0] en_wr
);

    localparam logic [ADDR_W:0] STS_END = (ADDR_W+1)'(NUM_BYTES);
    localparam logic [ADDR_W:0] WIN_END = (ADDR_W+1)'(2 * NUM_BYTES);

    logic [ADDR_W:0] addr_ext;
    logic [ADDR_W:0] en_off;
    logic            wr_req;

    assign addr_ext = {1'b0, bus_addr};
    assign en_off   = addr_ext - STS_END;
    assign wr_req   = bus_valid && bus_write;

    // Classify the address and form the index inside its half.
    always_comb begin
        region   = RG_NONE;
        byte_idx = '0;
        if (addr_ext < STS_END) begin
            region   = RG_STS;
            byte_idx = IDX_W'(addr_ext);
        end else if (addr_ext < WIN_END) begin
            region   = RG_EN;
            byte_idx = IDX_W'(en_off);
        end
    end

    // One write strobe per byte in each half.
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_strobe
        assign sts_wr[g] = wr_req && (addr_ext == (ADDR_W+1)'(g));
        assign en_wr[g]  = wr_req && (addr_ext == (ADDR_W+1)'(NUM_BYTES + g));
    end

endmodule

// File: rtl/gpe_reg_bank.sv
// Storage for the status and enable bytes.
// Status bytes are write-1-to-clear. The hotplug status bit is also set
// by the event input, and the event takes priority over a clear in the
// same cycle. Enable bytes are plain read/write storage.
// Assumes at most one write strobe is active per cycle.
module gpe_reg_bank
    import gpe_pkg::*;
#(
    parameter int NUM_BYTES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BYTES-1:0]  sts_wr,
    input  logic [NUM_BYTES-1:0]  en_wr,
    input  gpe_byte_t             wdata,
    input  logic                  hp_event,
    output gpe_byte_t             sts_q [NUM_BYTES],
    output gpe_byte_t             en_q  [NUM_BYTES]
);

    gpe_byte_t sts_r [NUM_BYTES];
    gpe_byte_t en_r  [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        localparam gpe_byte_t SET_MASK =
            (g == HP_BYTE) ? gpe_byte_t'(1 << HP_BIT) : '0;

        gpe_byte_t clr_mask;
        gpe_byte_t set_bits;

        assign clr_mask = sts_wr[g] ? wdata : '0;
        assign set_bits = hp_event ? SET_MASK : '0;

        // Status byte: clear bits written as 1, then apply event set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_r[g] <= '0;
            end else begin
                sts_r[g] <= (sts_r[g] & ~clr_mask) | set_bits;
            end
        end

        // Enable byte: full-byte load on write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_r[g] <= '0;
            end else if (en_wr[g]) begin
                en_r[g] <= wdata;
            end
        end

        assign sts_q[g] = sts_r[g];
        assign en_q[g]  = en_r[g];

        AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            en_wr[g] |=> (en_r[g] == $past(wdata)));  // R4

        AST_STS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            sts_wr[g] |=> ((sts_r[g] & $past(wdata) & ~SET_MASK) == '0));  // R3

        AST_STS_NO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((sts_r[g] & ~$past(sts_r[g]) & ~SET_MASK) == '0));  // R3

        AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !en_wr[g] |=> $stable(en_r[g]));  // R2
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hp_event |=> sts_r[HP_BYTE][HP_BIT]);  // R9

endmodule

// File: rtl/gpe_sci_ctrl.sv
// Interrupt-line controller for the hotplug event.
// Raises the line on an event while the hotplug enable bit is set.
// Lowers it when software turns the enable bit off, or when it clears the
// hotplug status bit from 1 to 0. A disable write outranks a coincident
// event. The enable value used is the one held before the cycle.
module gpe_sci_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic hp_event,
    input  logic en_hp,
    input  logic sts_hp,
    input  logic sts0_wr,
    input  logic en0_wr,
    input  logic wdata_hp,
    output logic sci
);

    logic disable_wr;
    logic sts_drop;
    logic raise;

    assign disable_wr = en0_wr && !wdata_hp;
    assign sts_drop   = sts0_wr && wdata_hp && sts_hp && !hp_event;
    assign raise      = hp_event && en_hp;

    // Interrupt flag, which also drives the output line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sci <= 1'b0;
        end else if (disable_wr) begin
            sci <= 1'b0;
        end else if (raise) begin
            sci <= 1'b1;
        end else if (sci && sts_drop) begin
            sci <= 1'b0;
        end
    end

    AST_SCI_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci) |-> $past(hp_event && en_hp));  // R5

    AST_SCI_QUIET_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sci && !hp_event) |=> !sci);  // R6

    AST_SCI_DROP_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sci && sts_drop) |=> !sci);  // R7

    AST_SCI_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sci) |-> $past(disable_wr || sts_drop));  // R7

    AST_SCI_DROP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        disable_wr |=> !sci);  // R8

endmodule

// File: rtl/gpe_read_mux.sv
// Read-data selector for the register window.
// Returns the addressed status or enable byte during a read request,
// and 0 for addresses outside the window and when no read is requested.
module gpe_read_mux
    import gpe_pkg::*;
#(
    parameter int NUM_BYTES = 2,
    localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic             rd_req,
    input  gpe_region_e      region,
    input  logic [IDX_W-1:0] byte_idx,
    input  gpe_byte_t        sts_q [NUM_BYTES],
    input  gpe_byte_t        en_q  [NUM_BYTES],
    output gpe_byte_t        rdata
);

    // Select one byte by region and index; default 0.
    always_comb begin
        rdata = '0;
        if (rd_req) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                if (byte_idx == IDX_W'(i)) begin
                    if (region == RG_STS) rdata = sts_q[i];
                    if (region == RG_EN)  rdata = en_q[i];
                end
            end
        end
    end

endmodule

// File: rtl/gpe_sci_block.sv
// Top of the general-purpose event block.
// Provides a byte-wide window of NUM_BYTES status bytes followed by
// NUM_BYTES enable bytes, and a level interrupt tied to the hotplug bit.
// Assumes single-cycle accesses and a one-cycle hotplug pulse.
module gpe_sci_block
    import gpe_pkg::*;
#(
    parameter int NUM_BYTES = 2,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              hp_event,
    output logic              sci
);

    localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    gpe_region_e            region;
    logic [IDX_W-1:0]       byte_idx;
    logic [NUM_BYTES-1:0]   sts_wr;
    logic [NUM_BYTES-1:0]   en_wr;
    gpe_byte_t              sts_q [NUM_BYTES];
    gpe_byte_t              en_q  [NUM_BYTES];

    gpe_addr_decode #(
        .NUM_BYTES (NUM_BYTES),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .region    (region),
        .byte_idx  (byte_idx),
        .sts_wr    (sts_wr),
        .en_wr     (en_wr)
    );

    gpe_reg_bank #(
        .NUM_BYTES (NUM_BYTES)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sts_wr   (sts_wr),
        .en_wr    (en_wr),
        .wdata    (bus_wdata),
        .hp_event (hp_event),
        .sts_q    (sts_q),
        .en_q     (en_q)
    );

    gpe_sci_ctrl u_sci (
        .clk      (clk),
        .rst_n    (rst_n),
        .hp_event (hp_event),
        .en_hp    (en_q[HP_BYTE][HP_BIT]),
        .sts_hp   (sts_q[HP_BYTE][HP_BIT]),
        .sts0_wr  (sts_wr[HP_BYTE]),
        .en0_wr   (en_wr[HP_BYTE]),
        .wdata_hp (bus_wdata[HP_BIT]),
        .sci      (sci)
    );

    gpe_read_mux #(
        .NUM_BYTES (NUM_BYTES)
    ) u_rmux (
        .rd_req   (bus_valid && !bus_write),
        .region   (region),
        .byte_idx (byte_idx),
        .sts_q    (sts_q),
        .en_q     (en_q),
        .rdata    (bus_rdata)
    );

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_oow
        AST_OOW_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && region == RG_NONE) |=> $stable(en_q[g]));  // R10

        AST_OOW_STS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && region == RG_NONE && !hp_event) |=> $stable(sts_q[g]));  // R10
    end

    AST_OOW_SCI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && region == RG_NONE && !hp_event) |=> $stable(sci));  // R10

endmodule

// File: tb/gpe_sci_block_bench.sv
module gpe_sci_block_bench;

    localparam int NB = 3;
    localparam int AW = 4;
    localparam int EN0 = NB;  // address of enable byte 0

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          hp_event = 1'b0;
    logic          sci;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    gpe_sci_block #(.NUM_BYTES(NB), .ADDR_W(AW)) u_gpe_sci_block (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hp_event(hp_event), .sci(sci)
    );

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // One bus cycle; optional coincident hotplug pulse.
    task automatic cycle(bit wr, int addr, logic [7:0] data, bit evt);
        @(negedge clk);
        bus_valid = wr;
        bus_write = wr;
        bus_addr  = AW'(addr);
        bus_wdata = data;
        hp_event  = evt;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        hp_event  = 1'b0;
    endtask

    task automatic wr(int addr, logic [7:0] data);
        cycle(1'b1, addr, data, 1'b0);
    endtask

    task automatic pulse();
        cycle(1'b0, 0, 8'h00, 1'b1);
    endtask

    task automatic rd(int addr, output logic [7:0] val);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = AW'(addr);
        #1;
        val = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic expect_rd(string req, int addr, logic [7:0] exp);
        logic [7:0] v;
        rd(addr, v);
        check(req, $sformatf("read addr %0d", addr), v, exp);
    endtask

    task automatic expect_sci(string req, bit exp);
        check(req, "sci level", {7'b0, sci}, {7'b0, exp});
    endtask

    task automatic t_reset();  // R1
        for (int a = 0; a < 2 * NB; a++) expect_rd("R1", a, 8'h00);
        expect_sci("R1", 1'b0);
    endtask

    task automatic t_enable_load();  // R4, R2
        wr(EN0 + 1, 8'hA5);
        expect_rd("R4", EN0 + 1, 8'hA5);
        wr(EN0 + 1, 8'h5A);
        expect_rd("R4", EN0 + 1, 8'h5A);
        expect_rd("R2", 1, 8'h00);
        wr(EN0 + 2, 8'hFF);
        expect_rd("R2", EN0, 8'h00);
        expect_rd("R2", 2, 8'h00);
        wr(2, 8'hFF);
        expect_rd("R2", EN0 + 2, 8'hFF);
    endtask

    task automatic t_event_masked();  // R6
        wr(EN0, 8'h00);
        pulse();
        expect_rd("R6", 0, 8'h08);
        expect_sci("R6", 1'b0);
        wr(EN0, 8'h08);
        expect_sci("R6", 1'b0);
        expect_rd("R6", EN0, 8'h08);
        wr(0, 8'h08);
        expect_rd("R3", 0, 8'h00);
    endtask

    task automatic t_event_raise_and_clear();  // R5, R3, R7
        pulse();
        expect_sci("R5", 1'b1);
        expect_rd("R5", 0, 8'h08);
        wr(0, 8'hF7);
        expect_rd("R3", 0, 8'h08);
        expect_sci("R7", 1'b1);
        wr(0, 8'h08);
        expect_rd("R3", 0, 8'h00);
        expect_sci("R7", 1'b0);
    endtask

    task automatic t_enable_off();  // R8
        pulse();
        expect_sci("R5", 1'b1);
        wr(EN0 + 1, 8'h00);
        expect_sci("R8", 1'b1);
        wr(EN0, 8'hF8);
        expect_sci("R8", 1'b1);
        expect_rd("R8", EN0, 8'hF8);
        wr(EN0, 8'hF0);
        expect_sci("R8", 1'b0);
        expect_rd("R8", EN0, 8'hF0);
        expect_rd("R8", 0, 8'h08);
        wr(0, 8'h08);
        expect_rd("R3", 0, 8'h00);
    endtask

    task automatic t_event_vs_clear();  // R9
        wr(EN0, 8'h08);
        pulse();
        expect_sci("R9", 1'b1);
        cycle(1'b1, 0, 8'h08, 1'b1);
        expect_rd("R9", 0, 8'h08);
        expect_sci("R9", 1'b1);
        wr(0, 8'h08);
        expect_sci("R7", 1'b0);
    endtask

    task automatic t_event_vs_disable();  // R11
        cycle(1'b1, EN0, 8'h00, 1'b1);
        expect_sci("R11", 1'b0);
        expect_rd("R11", 0, 8'h08);
        expect_rd("R11", EN0, 8'h00);
        wr(0, 8'h08);
    endtask

    task automatic t_out_of_window();  // R10
        for (int a = 2 * NB; a < (1 << AW); a++) wr(a, 8'hFF);
        for (int a = 0; a < NB; a++) expect_rd("R10", a, 8'h00);
        expect_rd("R10", EN0, 8'h00);
        expect_rd("R10", EN0 + 1, 8'h00);
        expect_rd("R10", EN0 + 2, 8'hFF);
        expect_rd("R10", 2 * NB, 8'h00);
        expect_rd("R10", (1 << AW) - 1, 8'h00);
        expect_sci("R10", 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_load();
        t_event_masked();
        t_event_raise_and_clear();
        t_enable_off();
        t_event_vs_clear();
        t_event_vs_disable();
        t_out_of_window();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule